// File: doc/BRIEF.md
# Paired Int64-to-Float32 Vector Converter

This block converts a 128-bit vector holding two signed 64-bit integer lanes into single-precision floating-point values. Each lane is treated as a two's-complement integer and is converted on its own. It is rounded to 24 significant bits under a 2-bit rounding-mode input. The 32-bit result of a lane fills both 32-bit words of that lane's 64-bit output slot.

The block accepts one request per cycle through a valid/ready handshake. One cycle later it presents the following as registered outputs:
- the converted vector;
- a destination write strobe;
- a per-operation inexact indication;
- a trap output.

It keeps two sticky flags: an inexact flag and a summary exception flag. If inexact exceptions are enabled and either lane rounded, the write strobe is withheld for the whole vector. When the facility-enable input is low, no conversion or flag update takes place and the trap output is raised instead.

Top module: `dual_i64_f32_cvt`

## Requirements
- R1: Lane 0 is `src_vec[63:0]` and lane 1 is `src_vec[127:64]`. Each lane is converted as a signed 64-bit integer to IEEE-754 single precision (1 sign bit, 8 exponent bits with bias 127, 23 fraction bits). Values of magnitude up to 2^24 are converted exactly.
- R2: The `rnd_mode` encoding is 00 = nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. It selects how the discarded bits of each lane are rounded.
- R3: Zero converts to 0x00000000 with no inexact. -2^63 converts exactly to 0xDF000000. A rounding carry out of the 24-bit significand raises the exponent by one, so 2^63-1 rounded to nearest gives 0x5F000000.
- R4: The 32-bit result of lane 0 appears in both `res_vec[31:0]` and `res_vec[63:32]`. The result of lane 1 appears in both `res_vec[95:64]` and `res_vec[127:96]`.
- R5: `inexact_o` is high for an operation exactly when the facility is enabled and at least one lane lost precision.
- R6: When an operation is inexact, `sticky_xx` and `sticky_fx` are both set. They then stay set until reset.
- R7: If `xe_en` is high and either lane is inexact, `res_we` stays low for that operation. Otherwise an enabled operation asserts `res_we` with the full 128-bit result.
- R8: A request with `fac_en` low raises `trap_unavail`. It keeps `res_we` and `inexact_o` low and leaves both sticky flags unchanged.
- R9: `in_ready` is always high. Every accepted request produces `out_valid` together with its results exactly one clock cycle later. No output pulse appears without a request.
- R10: After reset, `out_valid`, `res_we`, `inexact_o`, `trap_unavail`, `sticky_xx` and `sticky_fx` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted (always high) |
| src_vec | input | 128 | Two signed 64-bit integer lanes |
| rnd_mode | input | 2 | Rounding mode select |
| fac_en | input | 1 | Vector facility enable |
| xe_en | input | 1 | Inexact exception enable |
| out_valid | output | 1 | Result valid, one cycle after request |
| res_vec | output | 128 | Converted vector, each result duplicated in its lane |
| res_we | output | 1 | Destination write strobe |
| inexact_o | output | 1 | This operation rounded |
| sticky_xx | output | 1 | Sticky inexact flag |
| sticky_fx | output | 1 | Sticky summary exception flag |
| trap_unavail | output | 1 | Facility-unavailable trap |

## Verification
The assertions assume that `in_valid`, `fac_en` and `xe_en` are stable, known values on every rising edge after reset. They also assume that a request is judged only by the controls present in the same cycle. The stimulus changes inputs only on falling edges and drives all controls to defined values from time zero. The assertions also assume that the sticky flags can only be cleared by reset. The bench therefore never expects a flag to drop in mid-run.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } rnd_mode_e;

   // Decide whether the kept significand is bumped by one unit in the last place.
   function automatic logic round_up(input rnd_mode_e rm, input logic sign,
                                     input logic lsb, input logic guard,
                                     input logic sticky);
      logic lost;
      lost = guard | sticky;
      unique case (rm)
         RM_NEAR_EVEN: round_up = guard & (sticky | lsb);
         RM_TO_ZERO:   round_up = 1'b0;
         RM_TO_POS:    round_up = ~sign & lost;
         default:      round_up = sign & lost;
      endcase
   endfunction

endpackage

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
   parameter int W  = 64,
   parameter int PW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] pos
);

   if (W < 2) begin : g_bad_width
      $error("i2f_lead_one: W must be at least 2");
   end

   // Highest set bit wins; a zero vector reports position 0.
   always_comb begin
      pos = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) pos = PW'(i);
      end
   end

endmodule

// File: rtl/i2f_lane_cvt.sv
module i2f_lane_cvt
   import i2f_pkg::*;
#(
   parameter int INT_W = 64,
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [INT_W-1:0]         src,
   input  logic [1:0]               rnd_mode,
   output logic [EXP_W+MAN_W:0]     fp,
   output logic                     inexact
);

   localparam int SIG_W  = MAN_W + 1;
   localparam int PW     = $clog2(INT_W);
   localparam int DROP_W = INT_W - SIG_W;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

   if (DROP_W < 2) begin : g_bad_drop
      $error("i2f_lane_cvt: integer must exceed significand by 2 bits");
   end
   if (BIAS + INT_W >= (1 << EXP_W) - 1) begin : g_bad_range
      $error("i2f_lane_cvt: exponent field too narrow for integer range");
   end
   if (PW > EXP_W) begin : g_bad_pos
      $error("i2f_lane_cvt: position wider than exponent");
   end

   logic             sign;
   logic [INT_W-1:0] mag;
   logic [PW-1:0]    lead;
   logic [INT_W-1:0] norm;
   logic [SIG_W-1:0] kept;
   logic             guard;
   logic             sticky;
   logic             inc;
   logic [SIG_W:0]   sum;
   logic             nonzero;
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   rnd_mode_e        rm;

   assign rm   = rnd_mode_e'(rnd_mode);
   assign sign = src[INT_W-1];
   assign mag  = sign ? (~src + 1'b1) : src;

   i2f_lead_one #(.W(INT_W), .PW(PW)) lead_i (
      .vec (mag),
      .pos (lead)
   );

   // Left-justify so the leading one sits in the top bit.
   assign norm   = mag << (PW'(INT_W - 1) - lead);
   assign kept   = norm[INT_W-1 -: SIG_W];
   assign guard  = norm[DROP_W-1];
   assign sticky = |norm[DROP_W-2:0];
   assign inc    = round_up(rm, sign, kept[0], guard, sticky);
   assign sum    = {1'b0, kept} + {{SIG_W{1'b0}}, inc};

   // The hidden bit, or its carry, is set for every non-zero input.
   assign nonzero = sum[SIG_W] | sum[MAN_W];
   assign exp_f   = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(sum[SIG_W]);
   assign man_f   = sum[SIG_W] ? '0 : sum[MAN_W-1:0];

   assign fp      = nonzero ? {sign, exp_f, man_f} : '0;
   assign inexact = guard | sticky;

endmodule

// File: rtl/dual_i64_f32_cvt.sv
module dual_i64_f32_cvt #(
   parameter int LANES = 2,
   parameter int INT_W = 64,
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [LANES*INT_W-1:0]   src_vec,
   input  logic [1:0]               rnd_mode,
   input  logic                     fac_en,
   input  logic                     xe_en,
   output logic                     out_valid,
   output logic [LANES*INT_W-1:0]   res_vec,
   output logic                     res_we,
   output logic                     inexact_o,
   output logic                     sticky_xx,
   output logic                     sticky_fx,
   output logic                     trap_unavail
);

   localparam int FP_W  = 1 + EXP_W + MAN_W;
   localparam int VEC_W = LANES * INT_W;
   localparam int DUP   = INT_W / FP_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("dual_i64_f32_cvt: need at least one lane");
   end
   if (DUP * FP_W != INT_W) begin : g_bad_dup
      $error("dual_i64_f32_cvt: lane width must be a multiple of float width");
   end

   logic [VEC_W-1:0] lane_res;
   logic [LANES-1:0] lane_inx;
   logic             any_inx;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [FP_W-1:0] fp_w;

      i2f_lane_cvt #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) cvt_i (
         .src      (src_vec[l*INT_W +: INT_W]),
         .rnd_mode (rnd_mode),
         .fp       (fp_w),
         .inexact  (lane_inx[l])
      );

      for (genvar d = 0; d < DUP; d++) begin : g_dup
         assign lane_res[l*INT_W + d*FP_W +: FP_W] = fp_w;
      end
   end

   assign any_inx  = |lane_inx;
   assign in_ready = 1'b1;

   logic             vld_q, we_q, inx_q, trap_q, xx_q, fx_q;
   logic [VEC_W-1:0] res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         we_q   <= 1'b0;
         inx_q  <= 1'b0;
         trap_q <= 1'b0;
         xx_q   <= 1'b0;
         fx_q   <= 1'b0;
         res_q  <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            trap_q <= ~fac_en;
            inx_q  <= fac_en & any_inx;
            we_q   <= fac_en & ~(xe_en & any_inx);
            if (fac_en) res_q <= lane_res;
            if (fac_en & any_inx) begin
               xx_q <= 1'b1;
               fx_q <= 1'b1;
            end
         end else begin
            trap_q <= 1'b0;
            inx_q  <= 1'b0;
            we_q   <= 1'b0;
         end
      end
   end

   assign out_valid    = vld_q;
   assign res_vec      = res_q;
   assign res_we       = we_q;
   assign inexact_o    = inx_q;
   assign sticky_xx    = xx_q;
   assign sticky_fx    = fx_q;
   assign trap_unavail = trap_q;

endmodule

// File: rtl/dual_i64_f32_cvt_chk.sv
module dual_i64_f32_cvt_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic fac_en,
   input logic xe_en,
   input logic out_valid,
   input logic res_we,
   input logic inexact_o,
   input logic sticky_xx,
   input logic sticky_fx,
   input logic trap_unavail
);

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r8_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fac_en) |=> (trap_unavail && !res_we && !inexact_o));

   a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fac_en) |=> ($stable(sticky_xx) && $stable(sticky_fx)));

   a_r7_suppress: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fac_en && xe_en) |=> !(res_we && inexact_o));

   a_r6_set_on_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      inexact_o |-> (sticky_xx && sticky_fx));

   a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_xx |=> sticky_xx);

   a_r6_summary_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_fx |=> sticky_fx);

   a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!res_we && !trap_unavail && !inexact_o));

endmodule

bind dual_i64_f32_cvt dual_i64_f32_cvt_chk chk_i (.*);

// File: tb/dual_i64_f32_cvt_tb_top.sv
module dual_i64_f32_cvt_tb_top;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] src_vec = '0;
   logic [1:0]   rnd_mode = 2'b00;
   logic         fac_en = 1'b1;
   logic         xe_en = 1'b0;
   logic         out_valid;
   logic [127:0] res_vec;
   logic         res_we, inexact_o, sticky_xx, sticky_fx, trap_unavail;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_i64_f32_cvt dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .src_vec(src_vec), .rnd_mode(rnd_mode), .fac_en(fac_en), .xe_en(xe_en),
      .out_valid(out_valid), .res_vec(res_vec), .res_we(res_we),
      .inexact_o(inexact_o), .sticky_xx(sticky_xx), .sticky_fx(sticky_fx),
      .trap_unavail(trap_unavail)
   );

   typedef struct {
      logic [127:0] res;
      logic         we;
      logic         inx;
      logic         trap;
      logic         xx;
      logic         fx;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   logic m_xx = 1'b0;
   logic m_fx = 1'b0;
   bit   done = 1'b0;

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [127:0] act, input logic [127:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // Reference by exact integer remainder comparison.
   function automatic void ref_cvt(input logic [63:0] x, input logic [1:0] rm,
                                   output logic [31:0] f, output logic inx);
      logic        neg;
      logic [63:0] mag, q, rem, half, t;
      int          e, s;
      logic        up;
      neg = x[63];
      mag = neg ? (~x + 64'd1) : x;
      inx = 1'b0;
      if (mag == 64'd0) begin
         f = 32'd0;
         return;
      end
      e = 63;
      while (!mag[e]) e--;
      if (e <= 23) begin
         t = mag << (23 - e);
         f = {neg, 8'(127 + e), t[22:0]};
         return;
      end
      s    = e - 23;
      q    = mag >> s;
      rem  = mag - (q << s);
      half = 64'd1 << (s - 1);
      inx  = (rem != 64'd0);
      case (rm)
         2'b00:   up = (rem > half) || (rem == half && q[0]);
         2'b01:   up = 1'b0;
         2'b10:   up = !neg && inx;
         default: up = neg && inx;
      endcase
      q = q + {63'd0, up};
      if (q == (64'd1 << 24)) begin
         q = 64'd1 << 23;
         e++;
      end
      f = {neg, 8'(127 + e), q[22:0]};
   endfunction

   task automatic send(input logic [63:0] a0, input logic [63:0] a1,
                       input logic [1:0] rm, input logic fac, input logic xe,
                       input string tag);
      exp_t        it;
      logic [31:0] f0, f1;
      logic        i0, i1, anyi;
      ref_cvt(a0, rm, f0, i0);
      ref_cvt(a1, rm, f1, i1);
      anyi    = fac && (i0 || i1);
      if (anyi) begin
         m_xx = 1'b1;
         m_fx = 1'b1;
      end
      it.res  = {f1, f1, f0, f0};
      it.we   = fac && !(xe && anyi);
      it.inx  = anyi;
      it.trap = !fac;
      it.xx   = m_xx;
      it.fx   = m_fx;
      it.tag  = tag;
      exp_q.push_back(it);
      src_vec  = {a1, a0};
      rnd_mode = rm;
      fac_en   = fac;
      xe_en    = xe;
      in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops the expected item when a result emerges.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected out_valid", 128'd1, 128'd0);
         end else begin
            exp_t it;
            it = exp_q.pop_front();
            check(res_we == it.we, it.tag, "res_we (R7)", 128'(res_we), 128'(it.we));
            check(trap_unavail == it.trap, it.tag, "trap (R8)", 128'(trap_unavail), 128'(it.trap));
            check(inexact_o == it.inx, it.tag, "inexact (R5)", 128'(inexact_o), 128'(it.inx));
            check(sticky_xx == it.xx && sticky_fx == it.fx, it.tag, "sticky (R6)",
                  128'({sticky_xx, sticky_fx}), 128'({it.xx, it.fx}));
            if (it.we)
               check(res_vec == it.res, it.tag, "res_vec (R4)", res_vec, it.res);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!out_valid && !res_we && !inexact_o && !trap_unavail, "R10",
            "outputs in reset", 128'({out_valid, res_we, inexact_o, trap_unavail}), 128'd0);
      check(!sticky_xx && !sticky_fx, "R10", "flags in reset",
            128'({sticky_xx, sticky_fx}), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready, "R9", "in_ready high", 128'(in_ready), 128'd1);
      check(!out_valid, "R10", "idle after reset", 128'(out_valid), 128'd0);

      // R1 / R4: exact values, xe enabled, nothing inexact so flags stay clear
      send(64'd1, -64'sd1, 2'b00, 1'b1, 1'b1, "R1");
      send(64'd16777216, 64'd12345, 2'b01, 1'b1, 1'b1, "R4");
      // R3: zero and most negative value
      send(64'd0, 64'h8000_0000_0000_0000, 2'b10, 1'b1, 1'b1, "R3");
      // R8: disabled facility with inexact operand: no flag change
      send(64'd16777217, 64'd3, 2'b00, 1'b0, 1'b0, "R8");
      idle(1);
      // R5 / R6: inexact with exceptions disabled, write goes ahead
      send(64'd16777217, 64'd5, 2'b10, 1'b1, 1'b0, "R6");
      // R6: flags stay set over an exact operation
      send(64'd7, 64'd9, 2'b00, 1'b1, 1'b0, "R6");
      // R7: inexact with exceptions enabled in lane 1 only
      send(64'd2, 64'd16777219, 2'b00, 1'b1, 1'b1, "R7");
      // R2: ties and modes on both signs
      for (int m = 0; m < 4; m++) begin
         send(64'd16777217, -64'sd16777217, 2'(m), 1'b1, 1'b0, "R2");
         send(64'd16777219, -64'sd16777219, 2'(m), 1'b1, 1'b0, "R2");
         send(64'd16777218, -64'sd33554435, 2'(m), 1'b1, 1'b0, "R2");
         // R3: carry out of the significand
         send(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 2'(m), 1'b1, 1'b0, "R3");
      end
      // R1: random sweep in all modes
      for (int k = 0; k < 200; k++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom} >> (k % 50);
         b = {$urandom, $urandom} >> ((k * 7) % 60);
         send(a, b, 2'(k % 4), 1'b1, 1'(k % 3 == 0), "R1");
      end
      idle(3);
      check(exp_q.size() == 0, "R9", "all results returned", 128'(exp_q.size()), 128'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule